// File: doc/BRIEF.md
# Simulation Test Control Peripheral

A memory-mapped peripheral through which a processor running self-test code controls the simulation around it. The processor writes through a 32-bit slave port. A write to the halt register asks the system to stop. A write to the verdict register reports whether the current test passed. A write to the label-pointer register names the test that is running.

When the label pointer is written, the block becomes a bus master. It issues a burst of sequential 32-bit reads starting at the pointer and fills a 16-byte label buffer. The top byte of that buffer is always zero, so the label stays terminated whatever memory holds. Slave writes stall while the fetch runs, so a verdict written after a pointer is always reported against the complete new label. A write that hits no register raises an error pulse and touches no state. Reads of the window complete at once and return zero.

Top module: `simctl_top`

## Requirements
- R1: After reset, shutdown_req, result_valid, result_fail, addr_err and m_valid are 0, result_code and every bit of name_buf are 0, and s_ready is 1.
- R2: A write accepted (s_valid and s_ready high at a clock edge, s_write=1) at address BASE_ADDR+0 raises shutdown_req for exactly one cycle after the accepting edge, for any write data. No other pulse is raised.
- R3: An accepted write at BASE_ADDR+4 stores the data in result_code and raises result_valid for one cycle after the accepting edge. In that cycle result_fail is 1 when the data is non-zero and 0 when it is zero.
- R4: An accepted write at BASE_ADDR+8 with data P starts NAME_BYTES/4 master reads, in the order P, P+4, P+8, P+12. Each read completes on a clock edge with m_valid and m_ready both high. m_addr and m_valid hold while m_ready is low.
- R5: The word returned for the read at P+4k fills name_buf bytes 4k..4k+3, least significant byte first: byte j of the word goes to name_buf[8*(4k+j)+7 : 8*(4k+j)].
- R6: Once the fetch is complete, name_buf[127:120] (the last byte) is 0 whatever memory returned for it.
- R7: s_ready is 0 from the cycle after a label-pointer write is accepted until the cycle after the last master read completes. A write presented in that time is held off, then accepted.
- R8: An accepted write at any address other than BASE_ADDR+0, +4 or +8 raises addr_err for one cycle after the accepting edge. Misaligned offsets and offsets past the window count as such addresses. The write raises no other pulse, starts no master read, and leaves result_code and name_buf unchanged.
- R9: A read (s_write=0) is accepted whenever s_ready is 1. s_rdata is 0 for it, and it raises no pulse and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Slave request valid |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_ready | output | 1 | Slave request accepted when high with s_valid |
| s_rdata | output | 32 | Slave read data (always zero) |
| m_valid | output | 1 | Master read request valid |
| m_addr | output | 32 | Master read byte address |
| m_ready | input | 1 | Master read completes when high with m_valid |
| m_rdata | input | 32 | Master read data, valid with m_ready |
| shutdown_req | output | 1 | One-cycle halt request |
| result_valid | output | 1 | One-cycle verdict report |
| result_fail | output | 1 | Verdict flag, meaningful with result_valid |
| result_code | output | 32 | Last written verdict value |
| name_buf | output | 128 | Captured test label, byte 0 in bits 7:0 |
| addr_err | output | 1 | One-cycle bad-address write pulse |

## Verification
The bench builds the block with BASE_ADDR set to 0x80000040 rather than the default. This shows that decoding works on the offset from the base and not on absolute low address bits. It also makes addresses just below the base, and misaligned offsets inside the window, real error cases. NAME_BYTES stays at 16, so each fetch is four beats and the forced terminator lands in the last beat. The memory model stalls m_ready at random, which exercises address hold and the stall of a verdict write queued behind a fetch.

// File: rtl/simctl_pkg.sv
package simctl_pkg;
  localparam int WORD_BYTES = 4;
  localparam int REG_COUNT  = 3;

  typedef enum logic [1:0] {
    SEL_HALT    = 2'd0,
    SEL_VERDICT = 2'd1,
    SEL_LABEL   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/simctl_rst_sync.sv
module simctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sn = q2;
endmodule

// File: rtl/simctl_decode.sv
module simctl_decode
  import simctl_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [31:0] addr,
  output reg_sel_e    sel
);
  localparam logic [31:0] WIN_BYTES = 32'(REG_COUNT * WORD_BYTES);

  logic [31:0] offset;

  always_comb begin
    offset = addr - BASE_ADDR;
    if (offset[1:0] == 2'b00 && offset < WIN_BYTES) begin
      sel = reg_sel_e'(offset[3:2]);
    end else begin
      sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/simctl_fetch.sv
module simctl_fetch
  import simctl_pkg::*;
#(
  parameter int NAME_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_sn,
  input  logic                    start,
  input  logic [31:0]             ptr,
  output logic                    m_valid,
  output logic [31:0]             m_addr,
  input  logic                    m_ready,
  input  logic [31:0]             m_rdata,
  output logic [NAME_BYTES*8-1:0] name_buf
);
  localparam int NAME_W     = NAME_BYTES * 8;
  localparam int NAME_WORDS = NAME_BYTES / WORD_BYTES;
  localparam int BEAT_W     = (NAME_WORDS > 1) ? $clog2(NAME_WORDS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NAME_WORDS - 1);

  typedef enum logic { F_IDLE, F_RUN } fstate_e;

  fstate_e           state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [NAME_W-1:0] buf_q, buf_d;
  logic              last_beat;

  assign last_beat = (beat_q == LAST_BEAT);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    buf_d   = buf_q;
    case (state_q)
      F_IDLE: begin
        if (start) begin
          state_d = F_RUN;
          beat_d  = '0;
        end
      end
      F_RUN: begin
        if (m_ready) begin
          for (int k = 0; k < NAME_WORDS; k++) begin
            if (beat_q == BEAT_W'(k)) buf_d[32*k +: 32] = m_rdata;
          end
          if (last_beat) begin
            buf_d[NAME_W-1 -: 8] = 8'h00;
            state_d = F_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= F_IDLE;
      beat_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      buf_q   <= buf_d;
    end
  end

  assign m_valid  = (state_q == F_RUN);
  assign m_addr   = ptr + (32'(beat_q) << 2);
  assign name_buf = buf_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (m_valid && m_ready && !last_beat) |=> (m_valid && m_addr == $past(m_addr) + 32'd4));

  p_term_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(m_valid) |-> (name_buf[NAME_W-1 -: 8] == 8'h00));
endmodule

// File: rtl/simctl_top.sv
module simctl_top
  import simctl_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'hFFFF_0000,
  parameter int          NAME_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  input  logic                    s_write,
  input  logic [31:0]             s_addr,
  input  logic [31:0]             s_wdata,
  output logic                    s_ready,
  output logic [31:0]             s_rdata,
  output logic                    m_valid,
  output logic [31:0]             m_addr,
  input  logic                    m_ready,
  input  logic [31:0]             m_rdata,
  output logic                    shutdown_req,
  output logic                    result_valid,
  output logic                    result_fail,
  output logic [31:0]             result_code,
  output logic [NAME_BYTES*8-1:0] name_buf,
  output logic                    addr_err
);
  logic     rst_sn;
  reg_sel_e sel;
  logic     wr_acc;
  logic     halt_d, verdict_d, err_d, start;
  logic     halt_q, verdict_q, fail_q, err_q;
  logic     fail_d;
  logic [31:0] code_q, ptr_q;

  simctl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  simctl_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (.addr(s_addr), .sel(sel));

  always_comb begin
    wr_acc    = s_valid && s_ready && s_write;
    halt_d    = wr_acc && (sel == SEL_HALT);
    verdict_d = wr_acc && (sel == SEL_VERDICT);
    start     = wr_acc && (sel == SEL_LABEL);
    err_d     = wr_acc && (sel == SEL_NONE);
    fail_d    = verdict_d ? (s_wdata != 32'd0) : fail_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      halt_q    <= 1'b0;
      verdict_q <= 1'b0;
      fail_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= '0;
      ptr_q     <= '0;
    end else begin
      halt_q    <= halt_d;
      verdict_q <= verdict_d;
      fail_q    <= fail_d;
      err_q     <= err_d;
      if (verdict_d) code_q <= s_wdata;
      if (start)     ptr_q  <= s_wdata;
    end
  end

  simctl_fetch #(.NAME_BYTES(NAME_BYTES)) u_fetch (
    .clk(clk), .rst_sn(rst_sn), .start(start), .ptr(ptr_q),
    .m_valid(m_valid), .m_addr(m_addr), .m_ready(m_ready),
    .m_rdata(m_rdata), .name_buf(name_buf)
  );

  assign s_ready      = !m_valid;
  assign s_rdata      = '0;
  assign shutdown_req = halt_q;
  assign result_valid = verdict_q;
  assign result_fail  = fail_q;
  assign result_code  = code_q;
  assign addr_err     = err_q;

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (s_valid && s_ready && s_write && sel == SEL_HALT) |=>
      (shutdown_req && !result_valid && !addr_err));

  p_flag_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    result_valid |-> (result_fail == (result_code != 32'd0)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (s_valid && s_ready && s_write && sel == SEL_LABEL) |=> !s_ready);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    addr_err |-> ($stable(result_code) && !m_valid && !shutdown_req && !result_valid));
endmodule

// File: tb/sim_simctl_top.sv
module sim_simctl_top;
  localparam logic [31:0] BASE = 32'h8000_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_write = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic s_ready;
  logic [31:0] s_rdata;
  logic m_valid, m_ready = 1'b0;
  logic [31:0] m_addr, m_rdata;
  logic shutdown_req, result_valid, result_fail, addr_err;
  logic [31:0] result_code;
  logic [127:0] name_buf;

  int checks = 0, fails = 0;
  logic [31:0] beat_addr [0:7];
  int beat_n = 0;
  int stall_pct = 30;
  logic [31:0] exp_code = '0;
  logic [127:0] exp_name = '0;

  always #10 clk = ~clk;

  simctl_top #(.BASE_ADDR(BASE), .NAME_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_write(s_write),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_addr(m_addr), .m_ready(m_ready), .m_rdata(m_rdata),
    .shutdown_req(shutdown_req), .result_valid(result_valid),
    .result_fail(result_fail), .result_code(result_code),
    .name_buf(name_buf), .addr_err(addr_err)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {~a[7:0], a[15:8] ^ a[7:0], a[7:0] + 8'h13, a[7:0] ^ 8'h5A};
  endfunction

  function automatic logic [127:0] exp_label(input logic [31:0] p);
    logic [127:0] n;
    for (int k = 0; k < 4; k++) n[32*k +: 32] = mem_word(p + 32'(4*k));
    n[127:120] = 8'h00;
    return n;
  endfunction

  assign m_rdata = mem_word(m_addr);

  initial begin : responder
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      m_ready = (($urandom % 100) >= stall_pct);
      if (m_valid && m_ready && rst_n) begin
        if (beat_n < 8) beat_addr[beat_n] = m_addr;
        beat_n++;
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // drive one slave access; returns at the negedge right after acceptance
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_write = wr; s_addr = a; s_wdata = d;
    while (!s_ready) @(negedge clk);
    if (!wr) check("R9 rdata", {96'd0, s_rdata}, 128'd0);
    @(negedge clk);
    s_valid = 1'b0; s_write = 1'b0;
  endtask

  task automatic pulses(input string req, input logic h, input logic v, input logic e);
    check(req, {125'd0, shutdown_req, result_valid, addr_err}, {125'd0, h, v, e});
  endtask

  task automatic wait_idle();
    while (!s_ready) @(negedge clk);
  endtask

  task automatic do_label(input logic [31:0] p);
    beat_n = 0;
    access(1'b1, BASE + 32'd8, p);
    check("R7 stall", {127'd0, s_ready}, 128'd0);
    pulses("R4 no pulse", 1'b0, 1'b0, 1'b0);
    wait_idle();
    exp_name = exp_label(p);
    check("R4 beats", 128'(beat_n), 128'd4);
    for (int k = 0; k < 4; k++)
      check("R4 order", {96'd0, beat_addr[k]}, {96'd0, p + 32'(4*k)});
    check("R5 bytes", name_buf, exp_name);
    check("R6 term", {120'd0, name_buf[127:120]}, 128'd0);
  endtask

  task automatic do_verdict(input logic [31:0] d);
    access(1'b1, BASE + 32'd4, d);
    exp_code = d;
    pulses("R3 pulse", 1'b0, 1'b1, 1'b0);
    check("R3 flag", {127'd0, result_fail}, {127'd0, d != 32'd0});
    check("R3 code", {96'd0, result_code}, {96'd0, d});
    @(negedge clk);
    pulses("R3 one cycle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_halt(input logic [31:0] d);
    access(1'b1, BASE, d);
    pulses("R2 pulse", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    pulses("R2 one cycle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_bad(input logic [31:0] a, input logic [31:0] d);
    access(1'b1, a, d);
    pulses("R8 pulse", 1'b0, 1'b0, 1'b1);
    check("R8 no fetch", {127'd0, m_valid}, 128'd0);
    check("R8 code kept", {96'd0, result_code}, {96'd0, exp_code});
    check("R8 name kept", name_buf, exp_name);
  endtask

  task automatic do_read(input logic [31:0] a);
    access(1'b0, a, 32'hDEAD_BEEF);
    pulses("R9 no pulse", 1'b0, 1'b0, 1'b0);
    check("R9 code kept", {96'd0, result_code}, {96'd0, exp_code});
    check("R9 name kept", name_buf, exp_name);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    pulses("R1 pulses", 1'b0, 1'b0, 1'b0);
    check("R1 misc", {125'd0, result_fail, m_valid, s_ready}, 128'd1);
    check("R1 code", {96'd0, result_code}, 128'd0);
    check("R1 name", name_buf, 128'd0);

    // directed corners
    do_halt(32'd0);
    do_halt(32'hFFFF_FFFF);
    do_verdict(32'd0);
    do_verdict(32'd7);
    do_label(32'h0000_1000);
    do_bad(BASE + 32'd12, 32'h1);
    do_bad(BASE + 32'd2, 32'h2);
    do_bad(BASE - 32'd4, 32'h3);
    do_read(BASE + 32'd4);
    do_read(BASE + 32'd8);

    // R7: verdict queued behind a fetch sees the new label
    stall_pct = 60;
    beat_n = 0;
    @(negedge clk);
    s_valid = 1'b1; s_write = 1'b1; s_addr = BASE + 32'd8; s_wdata = 32'h0000_2203;
    @(negedge clk);
    s_addr = BASE + 32'd4; s_wdata = 32'h0;
    check("R7 held", {127'd0, s_ready}, 128'd0);
    while (!s_ready) begin
      check("R7 no report", {127'd0, result_valid}, 128'd0);
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_write = 1'b0;
    exp_name = exp_label(32'h0000_2203);
    exp_code = 32'h0;
    check("R7 report", {127'd0, result_valid}, 128'd1);
    check("R7 name at report", name_buf, exp_name);
    stall_pct = 30;

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      r = $urandom;
      case ($urandom % 5)
        0: do_halt(r);
        1: do_verdict(($urandom % 2) ? 32'd0 : r);
        2: do_label({r[31:2], 2'b00} ^ 32'h0000_0100);
        3: do_bad((($urandom % 2) ? BASE + 32'd12 + {r[7:0], 2'b00} : BASE + {28'd0, r[3:2], 2'b01}), r);
        default: do_read(BASE + {28'd0, r[3:0]});
      endcase
    end

    summary();
    $finish;
  end
endmodule